// File: doc/BRIEF.md
# Multi-Input Wake-Up Interrupt Unit

The unit watches a bank of asynchronous wake-up inputs arranged as groups of eight. Every input is first brought into the clock domain by a two-flop synchroniser. It is then checked against its own trigger rule: a level (active-high or active-low), a single edge (rising or falling), or both edges. When an enabled input fires, it latches a sticky pending flag. Software clears that flag by writing a one to the matching bit of the group's clear register.

Each group raises a request while any of its pending bits is set on an enabled input. A fixed group-to-line map, given as a parameter, combines the group requests onto fewer interrupt lines. With the default map, group 0 and group 3 share line 0. Groups 1 and 2 each own a line (lines 1 and 2). Groups 4 to 7 share line 3. Software configures and inspects the unit through a write port and an independent combinational read port. Both ports take the same address layout: group index in the upper bits and register type in the low three bits.

Top module: `wake_irq_unit`

## Requirements
- R1: After reset, every readable register of every group reads 0x00 and all interrupt lines are low.
- R2: Address bits [5:3] select the group and bits [2:0] select the register type: 0 trigger-mode, 1 polarity, 2 both-edges, 3 enable, 4 pending, 5 pending-clear. Types 0 to 3 read back the last byte written. Writes to type 4 have no effect. Types 5, 6 and 7 read 0x00.
- R3: With trigger-mode bit 1 (level), polarity bit 0 fires while the input is high and polarity bit 1 fires while it is low. A change on an input is first visible in pending after the third rising clock edge that follows it.
- R4: With trigger-mode bit 0 (edge) and both-edges bit 0, polarity bit 0 fires on a rising edge and polarity bit 1 fires on a falling edge.
- R5: With trigger-mode bit 0 and both-edges bit 1, both rising and falling edges fire, whatever the polarity bit holds.
- R6: An input whose enable bit is 0 never sets its pending bit.
- R7: A write to pending-clear clears exactly the pending bits written as 1. Writing 0xFF clears the whole group. A pending bit falls only through such a write.
- R8: A level-triggered input sets pending again on every cycle its active level persists, so a clear takes hold only once the level has gone inactive.
- R9: When a firing input and a clear of the same bit fall in the same cycle, the bit stays set.
- R10: Each interrupt line is the OR, over its mapped groups, of (pending AND enable). Default map: line 0 takes groups 0 and 3, line 1 group 1, line 2 group 2, line 3 groups 4 to 7. A line stays high until every contributing bit is cleared or disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wake_i | input | 64 | Asynchronous wake-up inputs, bit g*8+b is input b of group g |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Write address {group, type} |
| wr_data_i | input | 8 | Write data, one bit per input of the group |
| rd_addr_i | input | 6 | Read address {group, type} |
| rd_data_o | output | 8 | Combinational read data for rd_addr_i |
| irq_o | output | 4 | Combined interrupt request lines |

## Verification
Two situations are the hardest to reach from the ports. The first is a clear write that lands in exactly the cycle an edge is being latched. The bench gets there by counting clock edges from the input change, so that the write hits the third edge. The second is a level that keeps refiring through a clear. The bench holds the level, clears, and reads pending in the next cycle. A seeded random phase then toggles sparse input bits while writing random configuration and clear bytes. Every cycle, a cycle-level reference model in the bench is compared with the read port and the interrupt lines.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int REG_TYPE_W = 3;

  typedef enum logic [REG_TYPE_W-1:0] {
    REG_MODE = 3'd0,
    REG_POL  = 3'd1,
    REG_ANY  = 3'd2,
    REG_EN   = 3'd3,
    REG_PEND = 3'd4,
    REG_PCLR = 3'd5,
    REG_RSV6 = 3'd6,
    REG_RSV7 = 3'd7
  } wk_reg_e;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wk_group.sv
module wk_group
  import wk_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic         cfg_we_i,
  input  wk_reg_e      cfg_sel_i,
  input  logic [W-1:0] cfg_data_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] mode_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] any_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] hit_o,
  output logic         req_o
);
  logic [W-1:0] sync_s, prev_q;
  logic [W-1:0] mode_q, pol_q, any_q, en_q, pend_q;
  logic [W-1:0] rise, fall, edge_hit, lvl_hit, hit;

  wk_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (sync_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
      en_q   <= '0;
    end else if (cfg_we_i) begin
      unique case (cfg_sel_i)
        REG_MODE: mode_q <= cfg_data_i;
        REG_POL:  pol_q  <= cfg_data_i;
        REG_ANY:  any_q  <= cfg_data_i;
        REG_EN:   en_q   <= cfg_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rise     = sync_s & ~prev_q;
    fall     = ~sync_s & prev_q;
    edge_hit = (any_q & (rise | fall)) | (~any_q & ((rise & ~pol_q) | (fall & pol_q)));
    lvl_hit  = sync_s ^ pol_q;
    hit      = en_q & ((mode_q & lvl_hit) | (~mode_q & edge_hit));
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= sync_s;
      pend_q <= (pend_q & ~clr_i) | hit;
    end
  end

  assign mode_o = mode_q;
  assign pol_o  = pol_q;
  assign any_o  = any_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign hit_o  = hit;
  assign req_o  = |(pend_q & en_q);
endmodule

// File: rtl/wk_irq_merge.sv
module wk_irq_merge #(
  parameter int NUM_GROUPS = 8,
  parameter int NUM_IRQ    = 4,
  parameter int IRQ_SEL_W  = 2,
  parameter logic [NUM_GROUPS*IRQ_SEL_W-1:0] IRQ_MAP = 16'hFF24
) (
  input  logic [NUM_GROUPS-1:0] req_i,
  output logic [NUM_IRQ-1:0]    irq_o
);
  always_comb begin
    irq_o = '0;
    for (int l = 0; l < NUM_IRQ; l++) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (IRQ_MAP[g*IRQ_SEL_W +: IRQ_SEL_W] == IRQ_SEL_W'(l)) irq_o[l] = irq_o[l] | req_i[g];
      end
    end
  end
endmodule

// File: rtl/wake_irq_unit.sv
module wake_irq_unit
  import wk_pkg::*;
#(
  parameter int NUM_GROUPS  = 8,
  parameter int GROUP_W     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_IRQ     = 4,
  parameter int IRQ_SEL_W   = 2,
  parameter logic [NUM_GROUPS*IRQ_SEL_W-1:0] IRQ_MAP = 16'hFF24,
  localparam int GRP_IDX_W  = $clog2(NUM_GROUPS),
  localparam int ADDR_W     = GRP_IDX_W + REG_TYPE_W,
  localparam int NUM_INPUTS = NUM_GROUPS * GROUP_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_INPUTS-1:0] wake_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [GROUP_W-1:0]    wr_data_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [GROUP_W-1:0]    rd_data_o,
  output logic [NUM_IRQ-1:0]    irq_o
);
  logic [GRP_IDX_W-1:0] wr_grp, rd_grp;
  wk_reg_e              wr_type, rd_type;

  logic [GROUP_W-1:0] mode_q [NUM_GROUPS];
  logic [GROUP_W-1:0] pol_q  [NUM_GROUPS];
  logic [GROUP_W-1:0] any_q  [NUM_GROUPS];
  logic [GROUP_W-1:0] en_q   [NUM_GROUPS];
  logic [GROUP_W-1:0] pend_q [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] grp_req;

  logic [NUM_INPUTS-1:0] pend_flat, en_flat, hit_flat, clr_flat;

  assign wr_grp  = wr_addr_i[ADDR_W-1:REG_TYPE_W];
  assign wr_type = wk_reg_e'(wr_addr_i[REG_TYPE_W-1:0]);
  assign rd_grp  = rd_addr_i[ADDR_W-1:REG_TYPE_W];
  assign rd_type = wk_reg_e'(rd_addr_i[REG_TYPE_W-1:0]);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic               sel;
    logic [GROUP_W-1:0] clr;
    logic [GROUP_W-1:0] hit;

    assign sel = wr_en_i && (wr_grp == GRP_IDX_W'(g));
    assign clr = (sel && wr_type == REG_PCLR) ? wr_data_i : '0;

    wk_group #(.W(GROUP_W), .SYNC_STAGES(SYNC_STAGES)) u_group (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .raw_i     (wake_i[g*GROUP_W +: GROUP_W]),
      .cfg_we_i  (sel),
      .cfg_sel_i (wr_type),
      .cfg_data_i(wr_data_i),
      .clr_i     (clr),
      .mode_o    (mode_q[g]),
      .pol_o     (pol_q[g]),
      .any_o     (any_q[g]),
      .en_o      (en_q[g]),
      .pend_o    (pend_q[g]),
      .hit_o     (hit),
      .req_o     (grp_req[g])
    );

    assign pend_flat[g*GROUP_W +: GROUP_W] = pend_q[g];
    assign en_flat[g*GROUP_W +: GROUP_W]   = en_q[g];
    assign hit_flat[g*GROUP_W +: GROUP_W]  = hit;
    assign clr_flat[g*GROUP_W +: GROUP_W]  = clr;
  end

  always_comb begin
    rd_data_o = '0;
    if (32'(rd_grp) < NUM_GROUPS) begin
      unique case (rd_type)
        REG_MODE: rd_data_o = mode_q[rd_grp];
        REG_POL:  rd_data_o = pol_q[rd_grp];
        REG_ANY:  rd_data_o = any_q[rd_grp];
        REG_EN:   rd_data_o = en_q[rd_grp];
        REG_PEND: rd_data_o = pend_q[rd_grp];
        default:  rd_data_o = '0;
      endcase
    end
  end

  wk_irq_merge #(
    .NUM_GROUPS(NUM_GROUPS),
    .NUM_IRQ   (NUM_IRQ),
    .IRQ_SEL_W (IRQ_SEL_W),
    .IRQ_MAP   (IRQ_MAP)
  ) u_merge (
    .req_i(grp_req),
    .irq_o(irq_o)
  );
endmodule

// File: rtl/wake_irq_unit_chk.sv
module wake_irq_unit_chk #(
  parameter int NI = 64,
  parameter int NL = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NI-1:0] pend_i,
  input logic [NI-1:0] en_i,
  input logic [NI-1:0] hit_i,
  input logic [NI-1:0] clr_i,
  input logic [NL-1:0] irq_i
);
  assert_disabled_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & ~$past(pend_i) & ~$past(en_i)) == '0));

  assert_clear_only_by_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(pend_i) & ~pend_i & ~$past(clr_i)) == '0));

  assert_fire_always_latches_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(hit_i) & ~pend_i) == '0));

  assert_irq_needs_request_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_i) |-> (|(pend_i & en_i)));

  assert_request_reaches_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_i & en_i)) |-> (|irq_i));
endmodule

bind wake_irq_unit wake_irq_unit_chk #(.NI(NUM_INPUTS), .NL(NUM_IRQ)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .pend_i(pend_flat),
  .en_i  (en_flat),
  .hit_i (hit_flat),
  .clr_i (clr_flat),
  .irq_i (irq_o)
);

// File: tb/wake_irq_unit_test.sv
module wake_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] wake = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wake_irq_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .wake_i(wake), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  // reference model
  logic [63:0] m_s1, m_s2, m_d;
  logic [7:0]  m_mode [8];
  logic [7:0]  m_pol  [8];
  logic [7:0]  m_any  [8];
  logic [7:0]  m_en   [8];
  logic [7:0]  m_pend [8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_d <= '0;
      for (int g = 0; g < 8; g++) begin
        m_mode[g] <= '0; m_pol[g] <= '0; m_any[g] <= '0; m_en[g] <= '0; m_pend[g] <= '0;
      end
    end else begin
      for (int g = 0; g < 8; g++) begin
        logic [7:0] s, d, h, c, e;
        s = m_s2[g*8 +: 8];
        d = m_d[g*8 +: 8];
        e = (m_any[g] & (s ^ d)) | (~m_any[g] & ((m_pol[g] & ~s & d) | (~m_pol[g] & s & ~d)));
        h = m_en[g] & ((m_mode[g] & (s ^ m_pol[g])) | (~m_mode[g] & e));
        c = (wr_en && wr_addr[5:3] == 3'(g) && wr_addr[2:0] == 3'd5) ? wr_data : 8'h00;
        m_pend[g] <= (m_pend[g] & ~c) | h;
        if (wr_en && wr_addr[5:3] == 3'(g)) begin
          case (wr_addr[2:0])
            3'd0: m_mode[g] <= wr_data;
            3'd1: m_pol[g]  <= wr_data;
            3'd2: m_any[g]  <= wr_data;
            3'd3: m_en[g]   <= wr_data;
            default: ;
          endcase
        end
      end
      m_s1 <= wake;
      m_s2 <= m_s1;
      m_d  <= m_s2;
    end
  end

  function automatic logic [7:0] m_read(logic [5:0] a);
    int g = int'(a[5:3]);
    case (a[2:0])
      3'd0: return m_mode[g];
      3'd1: return m_pol[g];
      3'd2: return m_any[g];
      3'd3: return m_en[g];
      3'd4: return m_pend[g];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] m_irq();
    logic [7:0] r [8];
    for (int g = 0; g < 8; g++) r[g] = m_pend[g] & m_en[g];
    return {|{r[4], r[5], r[6], r[7]}, |r[2], |r[1], |{r[0], r[3]}};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic wr(int g, int t, logic [7:0] d);
    wr_en = 1'b1; wr_addr = {3'(g), 3'(t)}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdv(int g, int t, output logic [7:0] v);
    rd_addr = {3'(g), 3'(t)};
    #1;
    v = rd_data;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 64; a++) begin
      rdv(a / 8, a % 8, v);
      chk("R1", "reset read", 32'(v), 32'h0);
    end
    chk("R1", "reset irq", 32'(irq), 32'h0);

    // R2 readback, ignored pending write, clear reads zero
    wr(1, 0, 8'hA5);
    rdv(1, 0, v); chk("R2", "mode readback", 32'(v), 32'hA5);
    wr(1, 4, 8'hFF);
    rdv(1, 4, v); chk("R2", "pending write ignored", 32'(v), 32'h00);
    rdv(1, 5, v); chk("R2", "clear reads zero", 32'(v), 32'h00);
    wr(1, 0, 8'h00);

    // R3 / R8 / R6 level mode on group 2
    wr(2, 0, 8'hFF); wr(2, 1, 8'hF0); wr(2, 3, 8'hFF);
    idle(3);
    rdv(2, 4, v); chk("R3", "active-low level", 32'(v), 32'hF0);
    wake[23:16] = 8'hFF;
    idle(5);
    rdv(2, 4, v); chk("R3", "active-high level", 32'(v), 32'hFF);
    wr(2, 5, 8'hFF);
    rdv(2, 4, v); chk("R8", "high level refires", 32'(v), 32'h0F);
    wake[23:16] = 8'h00;
    idle(5);
    wr(2, 5, 8'hFF);
    rdv(2, 4, v); chk("R8", "low level refires", 32'(v), 32'hF0);
    chk("R10", "group 2 on line 2", 32'(irq), 32'h4);
    wr(2, 3, 8'h00);
    chk("R10", "disabled bits masked", 32'(irq), 32'h0);
    wr(2, 5, 8'hFF);
    idle(2);
    rdv(2, 4, v); chk("R6", "disabled level no set", 32'(v), 32'h00);
    wr(2, 0, 8'h00); wr(2, 1, 8'h00);

    // R4 / R5 / R7 edge mode on group 0
    wr(0, 1, 8'h2C); wr(0, 2, 8'h30); wr(0, 3, 8'h3F);
    wake[7:0] = 8'hFF;
    idle(2);
    rdv(0, 4, v); chk("R3", "not before third edge", 32'(v), 32'h00);
    idle(1);
    rdv(0, 4, v); chk("R4", "rising and both-edge", 32'(v), 32'h33);
    chk("R10", "group 0 on line 0", 32'(irq), 32'h1);
    wr(0, 5, 8'hFF);
    rdv(0, 4, v); chk("R7", "clear all edges", 32'(v), 32'h00);
    wake[7:0] = 8'h00;
    idle(5);
    rdv(0, 4, v); chk("R5", "falling and both-edge", 32'(v), 32'h3C);
    wr(0, 5, 8'h14);
    rdv(0, 4, v); chk("R7", "partial clear", 32'(v), 32'h28);
    wr(0, 5, 8'hFF);
    rdv(0, 4, v); chk("R7", "full clear", 32'(v), 32'h00);

    // R10 shared lines
    wr(3, 0, 8'h01); wr(3, 3, 8'h01);
    wake[24] = 1'b1;
    idle(5);
    chk("R10", "group 3 on line 0", 32'(irq), 32'h1);
    wr(7, 0, 8'h80); wr(7, 3, 8'h80);
    wake[63] = 1'b1;
    idle(5);
    chk("R10", "group 7 on line 3", 32'(irq), 32'h9);
    wake[24] = 1'b0;
    idle(3);
    wr(3, 5, 8'h01);
    idle(1);
    chk("R10", "line 0 drops after clear", 32'(irq), 32'h8);

    // R9 set beats clear in the same cycle
    wr(1, 3, 8'h01);
    wake[8] = 1'b1;
    idle(2);
    wr(1, 5, 8'hFF);
    rdv(1, 4, v); chk("R9", "set wins over clear", 32'(v), 32'h01);
    wr(1, 5, 8'h01);
    rdv(1, 4, v); chk("R7", "clear after collision", 32'(v), 32'h00);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] exp;
      exp = m_read(rd_addr);
      chk("R10", "random irq", 32'(irq), 32'(m_irq()));
      chk(rd_addr[2:0] == 3'd4 ? "R3" : "R2", "random read", 32'(rd_data), 32'(exp));
      if ($urandom % 4 == 0) wake = wake ^ (64'd1 << ($urandom % 64));
      wr_en   = ($urandom % 4 == 0);
      wr_addr = 6'($urandom);
      wr_data = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
      rd_addr = 6'($urandom);
      @(negedge clk);
    end
    wr_en = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule